// File: doc/BRIEF.md
# Echo Replica Balance Filter

This block builds a digital estimate of the echo that the transmit signal of a two-wire line leaks back into the receive direction, and subtracts that estimate from the receive samples. Each transmit sample feeds two sections: an 8-tap FIR and a second-order recursive (biquad) section. The two section results are added to form the echo estimate, which is then subtracted from the receive sample that arrived with the same strobe.

Samples arrive at the 16 kHz line rate as a one-cycle strobe carrying one signed 16-bit transmit sample and one signed 16-bit receive sample. A single multiply-accumulate unit works through all thirteen product terms one per clock cycle, then presents the cancelled receive sample together with a one-cycle done strobe. Software loads every coefficient through a small write port. A control bit switches cancellation off for loopback diagnostics. That bit is set at reset, so the filter stays inactive until all coefficients have been written and the bit is cleared. While cancellation is off, the filter state keeps running, so turning cancellation back on causes no transient.

Top module: `echo_balance_filter`

## Requirements
- R1: After reset `out_vld`, `rx_out` and `echo_est` are 0. The delay line, the recursive state and all coefficients are 0, and the cancel-off bit is 1.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` as follows. Addresses 0..7 hold FIR taps h0..h7, where h0 weights the newest transmit sample. Addresses 8, 9 and 10 hold feedforward b0, b1 and b2. Addresses 11 and 12 hold feedback a1 and a2. Bit 0 of address 15 is the cancel-off bit. Writes to addresses 13 and 14 change nothing.
- R3: `out_vld` goes high for exactly one cycle, 13 clock edges after the edge that accepted `in_vld`.
- R4: The FIR part of the sum is the sum of hk·x[n−k] for k = 0..7, where x[n] is the transmit sample just accepted.
- R5: The recursive sum is s = b0·x[n] + b1·x[n−1] + b2·x[n−2] + a1·y[n−1] + a2·y[n−2]. The new state is y[n] = sat16(floor(s / 2^14)). Coefficients are Q1.14, so 16384 represents 1.0.
- R6: With cancellation on, `echo_est` = sat16(floor((FIR sum + s) / 2^14)) and `rx_out` = sat16(rx − `echo_est`).
- R7: With the cancel-off bit at 1, `echo_est` is 0 and `rx_out` equals the receive sample. The delay line and the recursive state still update, so results after re-enabling are the same as if cancellation had never been off.
- R8: sat16 clamps to the range −32768..32767. This applies both to the echo estimate and to the subtraction.
- R9: A strobe that arrives while a sample is being processed is ignored. It shifts no sample into the delay line and produces no extra `out_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient/control write enable |
| cfg_addr | input | 4 | Write address |
| cfg_wdata | input | 16 | Write data |
| in_vld | input | 1 | Sample strobe |
| tx_in | input | 16 | Signed transmit sample (drives the echo estimate) |
| rx_in | input | 16 | Signed receive sample to be cleaned |
| out_vld | output | 1 | Done strobe for one output sample |
| rx_out | output | 16 | Receive sample minus echo estimate |
| echo_est | output | 16 | Echo estimate used for this sample |

## Verification
Two events can fall into one processing window: a new sample strobe arriving while the multiply-accumulate sequence is still running, and the final edge that issues the done strobe. The bench raises an extra strobe in the middle of a sequence with a distinct transmit value. If that strobe were accepted, the delay-line contents would shift and both later outputs and the spacing of `out_vld` would change. Separately, the saturation corner is reached in the same cycle as the subtraction by loading maximal taps. The bench reference model computes the clamped estimate and the clamped difference independently, and it compares `out_vld` on every clock.

// File: rtl/echo_balance_filter.sv
module echo_balance_filter #(
  parameter int DW   = 16,
  parameter int FRAC = 14,
  parameter int AW   = 40,
  parameter int NTAP = 8,
  parameter int AAW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AAW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          in_vld,
  input  logic [DW-1:0] tx_in,
  input  logic [DW-1:0] rx_in,
  output logic          out_vld,
  output logic [DW-1:0] rx_out,
  output logic [DW-1:0] echo_est
);
  localparam int NIIR  = 5;
  localparam int NTERM = NTAP + NIIR;
  localparam int CNTW  = $clog2(NTERM);
  localparam int TW    = $clog2(NTAP);
  localparam int PW    = 2 * DW;
  localparam logic [CNTW-1:0] LAST = CNTW'(NTERM - 1);
  localparam logic [AAW-1:0] CTRL_ADDR = '1;

  logic signed [DW-1:0] hc [NTAP];
  logic signed [DW-1:0] ic [NIIR];
  logic signed [DW-1:0] d  [NTAP];
  logic signed [DW-1:0] y1, y2, rx_s;
  logic signed [AW-1:0] acc;
  logic [CNTW-1:0] cnt;
  logic busy, bypass;

  function automatic logic signed [DW-1:0] sat(input logic signed [AW-1:0] v);
    if (&v[AW-1:DW-1] || ~|v[AW-1:DW-1]) return v[DW-1:0];
    return v[AW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  endfunction

  logic [CNTW-1:0] fpos;
  logic [2:0] iidx;
  logic [TW-1:0] tidx;
  logic signed [DW-1:0] csel, osel;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc_nxt, diff;
  logic signed [DW-1:0] rep;
  logic [AAW-1:0] ioff;

  assign fpos = cnt - CNTW'(NIIR);
  assign tidx = fpos[TW-1:0];
  assign iidx = cnt[2:0];
  assign ioff = cfg_addr - AAW'(NTAP);

  always_comb begin
    if (cnt < CNTW'(NIIR)) begin
      csel = ic[iidx];
      if (iidx == 3'd3)      osel = y1;
      else if (iidx == 3'd4) osel = y2;
      else                   osel = d[TW'(iidx)];
    end else begin
      csel = hc[tidx];
      osel = d[tidx];
    end
  end

  assign prod    = csel * osel;
  assign acc_nxt = acc + AW'(prod);
  assign rep     = bypass ? '0 : sat(acc_nxt >>> FRAC);
  assign diff    = AW'(rx_s) - AW'(rep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAP; i++) begin hc[i] <= '0; d[i] <= '0; end
      for (int i = 0; i < NIIR; i++) ic[i] <= '0;
      bypass <= 1'b1;
    end else begin
      if (cfg_we) begin
        if (cfg_addr < AAW'(NTAP))              hc[cfg_addr[TW-1:0]] <= cfg_wdata;
        else if (cfg_addr < AAW'(NTERM))        ic[ioff[2:0]] <= cfg_wdata;
        else if (cfg_addr == CTRL_ADDR)         bypass <= cfg_wdata[0];
      end
      if (in_vld && !busy) begin
        d[0] <= tx_in;
        for (int i = 1; i < NTAP; i++) d[i] <= d[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; acc <= '0; y1 <= '0; y2 <= '0; rx_s <= '0;
      out_vld <= 1'b0; rx_out <= '0; echo_est <= '0;
    end else begin
      out_vld <= 1'b0;
      if (!busy) begin
        if (in_vld) begin
          busy <= 1'b1; cnt <= '0; acc <= '0; rx_s <= rx_in;
        end
      end else begin
        acc <= acc_nxt;
        cnt <= cnt + 1'b1;
        if (cnt == CNTW'(NIIR - 1)) begin
          y1 <= sat(acc_nxt >>> FRAC);
          y2 <= y1;
        end
        if (cnt == LAST) begin
          busy     <= 1'b0;
          cnt      <= '0;
          out_vld  <= 1'b1;
          echo_est <= rep;
          rx_out   <= sat(diff);
        end
      end
    end
  end
endmodule

module echo_balance_filter_chk #(parameter int DW = 16, parameter int CNTW = 4, parameter int LASTV = 12) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic          busy,
  input logic [CNTW-1:0] cnt,
  input logic          bypass,
  input logic          out_vld,
  input logic [DW-1:0] rx_out,
  input logic [DW-1:0] echo_est,
  input logic [DW-1:0] rx_s
);
  // R3
  one_cycle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);
  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(busy) && $past(cnt) == CNTW'(LASTV));
  // R9
  busy_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != CNTW'(LASTV) |=> busy && cnt == $past(cnt) + 1'b1);
  // R9
  strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && busy |=> $stable(rx_s));
  // R7
  bypass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && $past(bypass) |-> echo_est == '0 && rx_out == $past(rx_s));
endmodule

bind echo_balance_filter echo_balance_filter_chk #(.DW(DW), .CNTW(CNTW), .LASTV(NTERM - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .busy(busy), .cnt(cnt), .bypass(bypass),
  .out_vld(out_vld), .rx_out(rx_out), .echo_est(echo_est), .rx_s(rx_s));

// File: tb/sim_echo_balance_filter.sv
module sim_echo_balance_filter;
  logic clk = 0, rst_n = 0, cfg_we = 0, in_vld = 0;
  logic [3:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0, tx_in = '0, rx_in = '0;
  logic out_vld;
  logic [15:0] rx_out, echo_est;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  echo_balance_filter u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_vld(in_vld), .tx_in(tx_in), .rx_in(rx_in),
    .out_vld(out_vld), .rx_out(rx_out), .echo_est(echo_est));

  longint h[8], b[3], a[2], xq[$], ym1, ym2;
  bit byp;
  longint exp_rx, exp_est;

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic model(longint x, longint r);
    longint fir, iir, yn;
    xq.push_front(x);
    void'(xq.pop_back());
    fir = 0;
    for (int k = 0; k < 8; k++) fir += h[k] * xq[k];
    iir = b[0]*xq[0] + b[1]*xq[1] + b[2]*xq[2] + a[0]*ym1 + a[1]*ym2;
    yn = sat(iir >>> 14);
    ym2 = ym1; ym1 = yn;
    exp_est = byp ? 0 : sat((fir + iir) >>> 14);
    exp_rx = sat(r - exp_est);
  endtask

  task automatic wr(int addr, longint val);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(addr); cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 0;
    if (addr < 8) h[addr] = longint'($signed(16'(val)));
    else if (addr < 11) b[addr-8] = longint'($signed(16'(val)));
    else if (addr < 13) a[addr-11] = longint'($signed(16'(val)));
    else if (addr == 15) byp = val[0];
  endtask

  task automatic run(longint x, longint r, int extra, string req);
    @(negedge clk);
    tx_in = 16'(x); rx_in = 16'(r); in_vld = 1;
    model(x, r);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      in_vld = (k == extra);
      if (k == extra) begin tx_in = 16'h1234; rx_in = 16'h4321; end
      // R3: done exactly 13 edges after acceptance (14th falling edge here)
      chk(out_vld == (k == 14), "R3", longint'(out_vld), longint'(k == 14));
      if (k == 14) begin
        chk(longint'($signed(echo_est)) == exp_est, req, longint'($signed(echo_est)), exp_est);
        chk(longint'($signed(rx_out)) == exp_rx, req, longint'($signed(rx_out)), exp_rx);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin h[k] = 0; xq.push_back(0); end
    b = '{0, 0, 0}; a = '{0, 0}; ym1 = 0; ym2 = 0; byp = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_vld == 0, "R1", longint'(out_vld), 0);
    chk(rx_out == 0, "R1", longint'(rx_out), 0);
    chk(echo_est == 0, "R1", longint'(echo_est), 0);
    rst_n = 1;
    // R1/R7: cancel-off bit set after reset, output passes receive sample
    run(1000, -777, 0, "R1");
    // R2: load coefficients, leave cancellation off for now
    wr(0, 16384); wr(1, -8192); wr(2, 4096); wr(3, 1000);
    wr(4, -500); wr(5, 250); wr(6, 0); wr(7, -3000);
    wr(8, 8192); wr(9, 2000); wr(10, -1000); wr(11, 6000); wr(12, -3000);
    wr(15, 0);
    // R4/R6 impulse
    run(8000, 0, 0, "R4");
    for (int i = 0; i < 8; i++) run(0, 100 * i, 0, "R5");
    // R6 mixed pattern
    run(-12000, 3000, 0, "R6");
    run(20000, -15000, 0, "R6");
    run(-5, 17, 0, "R6");
    // R2: writes to 13 and 14 have no effect
    wr(13, 16'h7fff); wr(14, 16'h7fff);
    run(9000, 50, 0, "R2");
    // R9: strobe mid-sequence ignored
    run(-4000, 1200, 5, "R9");
    run(3000, -200, 0, "R9");
    // R7: cancel off, state keeps running, then back on
    wr(15, 1);
    run(11111, 2222, 0, "R7");
    run(-7000, -3333, 0, "R7");
    wr(15, 0);
    run(500, 600, 0, "R7");
    run(0, 0, 0, "R7");
    // R8: saturation of estimate and of difference
    for (int k = 0; k < 8; k++) wr(k, 32767);
    for (int i = 0; i < 9; i++) run(32767, -32768, 0, "R8");
    for (int i = 0; i < 9; i++) run(-32768, 32767, 0, "R8");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule